// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block lets an outside master borrow a processor's external memory bus. The master pulls an active-low request line low. The request may change at any time relative to the processor clock, so the block passes it through a synchronizer chain first. The block then stalls the memory controller so that no new access starts, and waits for any access already in flight to end. After that it releases every bus pin through a single output enable. A fixed number of cycles later it pulls the active-low acknowledge low. When the master lets go of the request, the block drives the bus again and raises the acknowledge one cycle later. A veto input can refuse hold requests for as long as it is held high.

The control is a five-state machine. IDLE_OWNED: the processor drives the bus and nothing is stalled. DRAIN: the stall is raised and the block waits for the controller's busy flag to drop. FLOAT: the pins are released but the acknowledge is not yet given. GRANTED: the outside master owns the bus. RECLAIM: the pins are re-driven before the acknowledge is removed. The transitions are:

- REQ: IDLE_OWNED to DRAIN, on a synchronized request with the veto low.
- DRAINED: DRAIN to FLOAT, once the minimum drain time has passed and busy is low.
- ACK: FLOAT to GRANTED, after the acknowledge gap.
- WITHDRAW: GRANTED to RECLAIM, when the request goes away.
- RECLAIMED: RECLAIM to IDLE_OWNED, at the end of the reclaim window.
- ABORT: DRAIN or FLOAT back to IDLE_OWNED, when the request goes away or the veto is raised before the acknowledge.

All delays are counted by one shared counter. The counter is cleared on every change of state.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset, and whenever the machine is in IDLE_OWNED, bus_oe is 1, hold_ack_n is 1 and mc_stall is 0.
- R2: A low hold_req_n is seen through a two-flop synchronizer. If hold_req_n goes low ahead of clock edge k, mc_stall rises after edge k+2 and the bus still drives until at least edge k+4.
- R3: bus_oe never falls while mc_busy was high at the deciding edge. With an idle bus, the pins float two cycles after mc_stall rises. Otherwise they float at the first edge that sees mc_busy low.
- R4: hold_ack_n falls exactly two cycles after bus_oe falls.
- R5: Suppose hold_req_n goes high ahead of edge k while the bus is granted. Then bus_oe returns to 1 after edge k+3, hold_ack_n returns to 1 after edge k+4, and mc_stall drops with it.
- R6: If the request is withdrawn in DRAIN or FLOAT, the machine returns to IDLE_OWNED and hold_ack_n never goes low. A withdrawal seen in the last FLOAT cycle wins over the grant.
- R7: While hold_veto is 1, a request is never granted. Raising the veto in DRAIN or FLOAT returns the machine to IDLE_OWNED at the next edge.
- R8: Once hold_ack_n is low, hold_veto has no effect; the grant lasts until the request is withdrawn.
- R9: mc_stall is 1 in DRAIN, FLOAT, GRANTED and RECLAIM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| hold_veto | input | 1 | 1 refuses all hold requests not yet acknowledged |
| mc_busy | input | 1 | Memory controller has an access in flight |
| mc_stall | output | 1 | Tells the memory controller to start no new access |
| hold_ack_n | output | 1 | Active-low grant to the outside master |
| bus_oe | output | 1 | Common output enable for every external bus pin |

## Verification
The assertions assume that reset is held low for at least two clock cycles, so that every look-back starts from reset values. They also assume that the memory controller lowers mc_busy within a bounded time once mc_stall is high. The bench changes hold_req_n, hold_veto and mc_busy only on falling clock edges, so the synchronizer delay is always exactly two edges. It keeps mc_busy high for a finite stretch only, and it clears the veto only after the request has been withdrawn and has left the synchronizer.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [2:0] {
        IDLE_OWNED = 3'd0,
        DRAIN      = 3'd1,
        FLOAT      = 3'd2,
        GRANTED    = 3'd3,
        RECLAIM    = 3'd4
    } arb_state_e;

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/bha_gap_counter.sv
module bha_gap_counter #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (count_o != TOP) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int DRAIN_MIN     = 2,
    parameter int ACK_GAP       = 2,
    parameter int RECLAIM_FLOAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    input  logic hold_veto,
    input  logic mc_busy,
    output logic mc_stall,
    output logic hold_ack_n,
    output logic bus_oe
);

    localparam int MAX_A   = (DRAIN_MIN - 1 > ACK_GAP - 1) ? DRAIN_MIN - 1 : ACK_GAP - 1;
    localparam int CNT_MAX = (MAX_A > RECLAIM_FLOAT) ? MAX_A : RECLAIM_FLOAT;
    localparam int CNT_W   = $clog2(CNT_MAX + 2);

    localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_MIN - 1);
    localparam logic [CNT_W-1:0] ACK_LAST   = CNT_W'(ACK_GAP - 1);
    localparam logic [CNT_W-1:0] RECL_LAST  = CNT_W'(RECLAIM_FLOAT);

    arb_state_e       state_q;
    arb_state_e       state_nx;
    logic             req_seen;
    logic [CNT_W-1:0] gap_cnt;
    logic             cnt_clear;

    // Request synchronizer: positive polarity inside the block
    bha_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (~hold_req_n),
        .sync_o  (req_seen)
    );

    // Shared delay counter, restarted on every state change
    assign cnt_clear = (state_nx != state_q);

    bha_gap_counter #(.WIDTH(CNT_W)) u_gap_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .count_o (gap_cnt)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            IDLE_OWNED: begin
                if (req_seen && !hold_veto) state_nx = DRAIN;        // REQ
            end
            DRAIN: begin
                if (!req_seen || hold_veto) state_nx = IDLE_OWNED;   // ABORT
                else if (gap_cnt >= DRAIN_LAST && !mc_busy)
                    state_nx = FLOAT;                                 // DRAINED
            end
            FLOAT: begin
                if (!req_seen || hold_veto) state_nx = IDLE_OWNED;   // ABORT
                else if (gap_cnt >= ACK_LAST) state_nx = GRANTED;    // ACK
            end
            GRANTED: begin
                if (!req_seen) state_nx = RECLAIM;                   // WITHDRAW
            end
            RECLAIM: begin
                if (gap_cnt >= RECL_LAST) state_nx = IDLE_OWNED;     // RECLAIMED
            end
            default: state_nx = IDLE_OWNED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE_OWNED;
        end else begin
            state_q <= state_nx;
        end
    end

    // Output decode
    always_comb begin
        mc_stall   = 1'b1;
        hold_ack_n = 1'b1;
        bus_oe     = 1'b1;
        unique case (state_q)
            IDLE_OWNED: begin
                mc_stall = 1'b0;
            end
            DRAIN: begin
            end
            FLOAT: begin
                bus_oe = 1'b0;
            end
            GRANTED: begin
                bus_oe     = 1'b0;
                hold_ack_n = 1'b0;
            end
            RECLAIM: begin
                hold_ack_n = 1'b0;
                bus_oe     = (gap_cnt >= RECL_LAST);
            end
            default: begin
                mc_stall = 1'b0;
            end
        endcase
    end

    // Assertions

    // R1: the processor owns the bus whenever nothing is stalled
    p_idle_owns_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_stall |-> (bus_oe && hold_ack_n));

    // R3: the pins are released only after the controller reported idle
    p_float_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> !$past(mc_busy));

    // R4: the acknowledge follows two cycles of floating pins
    p_ack_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> (!bus_oe && !$past(bus_oe, 1) && !$past(bus_oe, 2)));

    // R5: the bus is driven again one cycle before the acknowledge is removed
    p_reclaim_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |-> ($past(bus_oe) && !$past(hold_ack_n)));

    // R7: a veto seen before the grant keeps the acknowledge high
    p_veto_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_veto && hold_ack_n) |=> hold_ack_n);

    // R8: a grant persists while the synchronized request is present
    p_grant_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_ack_n && bus_oe == 1'b0 && req_seen) |=> !hold_ack_n);

    // R9: an acknowledged bus is always accompanied by a stall
    p_stall_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> mc_stall);

endmodule

// File: tb/bus_hold_arbiter_bench.sv
module bus_hold_arbiter_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic hold_req_n;
    logic hold_veto;
    logic mc_busy;
    logic mc_stall;
    logic hold_ack_n;
    logic bus_oe;

    int cyc    = 0;
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    always @(posedge clk) cyc <= cyc + 1;

    bus_hold_arbiter u_bus_hold_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req_n (hold_req_n),
        .hold_veto  (hold_veto),
        .mc_busy    (mc_busy),
        .mc_stall   (mc_stall),
        .hold_ack_n (hold_ack_n),
        .bus_oe     (bus_oe)
    );

    typedef struct {
        int    cyc;
        logic  oe;
        logic  ack;
        logic  stl;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // Driver side: queue expected outputs for cycles a..b
    task automatic expect_span(int a, int b, logic oe, logic ack, logic stl, string tag);
        for (int k = a; k <= b; k++) begin
            exp_t e;
            e.cyc = k; e.oe = oe; e.ack = ack; e.stl = stl; e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic to_cyc(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        exp_t e;
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            e = exp_q.pop_front();
            n_run++;
            if (e.cyc != cyc || bus_oe !== e.oe || hold_ack_n !== e.ack || mc_stall !== e.stl) begin
                n_fail++;
                $display("FAIL %s cyc %0d: oe/ack_n/stall = %b%b%b expected %b%b%b",
                         e.tag, cyc, bus_oe, hold_ack_n, mc_stall, e.oe, e.ack, e.stl);
            end
        end
    end

    // Grant on an idle bus, starting at the current falling edge (R2, R3, R4, R9)
    task automatic grant_idle();
        int c;
        c = cyc;
        hold_req_n = 1'b0;
        expect_span(c + 1, c + 2,  1'b1, 1'b1, 1'b0, "R2");
        expect_span(c + 3, c + 4,  1'b1, 1'b1, 1'b1, "R9");
        expect_span(c + 5, c + 6,  1'b0, 1'b1, 1'b1, "R3");
        expect_span(c + 7, c + 10, 1'b0, 1'b0, 1'b1, "R4");
        to_cyc(c + 10);
    endtask

    // Withdraw the request while granted (R5)
    task automatic release_bus();
        int d;
        d = cyc;
        hold_req_n = 1'b1;
        expect_span(d + 1, d + 3, 1'b0, 1'b0, 1'b1, "R5");
        expect_span(d + 4, d + 4, 1'b1, 1'b0, 1'b1, "R5");
        expect_span(d + 5, d + 7, 1'b1, 1'b1, 1'b0, "R5");
        to_cyc(d + 8);
    endtask

    initial begin
        int c;
        rst_n      = 1'b0;
        hold_req_n = 1'b1;
        hold_veto  = 1'b0;
        mc_busy    = 1'b0;
        @(negedge clk);
        expect_span(cyc + 1, cyc + 3, 1'b1, 1'b1, 1'b0, "R1");
        to_cyc(4);
        rst_n = 1'b1;
        expect_span(5, 7, 1'b1, 1'b1, 1'b0, "R1");
        to_cyc(8);

        // Basic grant and release
        grant_idle();
        release_bus();

        // R3: access in flight delays the float until busy drops
        c = cyc;
        mc_busy    = 1'b1;
        hold_req_n = 1'b0;
        expect_span(c + 1, c + 2, 1'b1, 1'b1, 1'b0, "R2");
        expect_span(c + 3, c + 8, 1'b1, 1'b1, 1'b1, "R3");
        to_cyc(c + 8);
        mc_busy = 1'b0;
        expect_span(c + 9,  c + 10, 1'b0, 1'b1, 1'b1, "R3");
        expect_span(c + 11, c + 12, 1'b0, 1'b0, 1'b1, "R4");
        to_cyc(c + 12);
        release_bus();

        // R6: withdrawal in the last FLOAT cycle beats the grant
        c = cyc;
        hold_req_n = 1'b0;
        to_cyc(c + 4);
        hold_req_n = 1'b1;
        expect_span(c + 5, c + 6, 1'b0, 1'b1, 1'b1, "R6");
        expect_span(c + 7, c + 9, 1'b1, 1'b1, 1'b0, "R6");
        to_cyc(c + 10);

        // R6: withdrawal during DRAIN never floats the bus
        c = cyc;
        hold_req_n = 1'b0;
        to_cyc(c + 2);
        hold_req_n = 1'b1;
        expect_span(c + 3, c + 4, 1'b1, 1'b1, 1'b1, "R6");
        expect_span(c + 5, c + 8, 1'b1, 1'b1, 1'b0, "R6");
        to_cyc(c + 9);

        // R7: veto high refuses a request outright
        c = cyc;
        hold_veto  = 1'b1;
        hold_req_n = 1'b0;
        expect_span(c + 1, c + 12, 1'b1, 1'b1, 1'b0, "R7");
        to_cyc(c + 12);
        hold_req_n = 1'b1;
        to_cyc(c + 16);
        hold_veto = 1'b0;
        expect_span(c + 17, c + 19, 1'b1, 1'b1, 1'b0, "R7");
        to_cyc(c + 20);

        // R7: veto raised during DRAIN aborts
        c = cyc;
        hold_req_n = 1'b0;
        to_cyc(c + 3);
        hold_veto = 1'b1;
        expect_span(c + 3, c + 3, 1'b1, 1'b1, 1'b1, "R7");
        expect_span(c + 4, c + 6, 1'b1, 1'b1, 1'b0, "R7");
        to_cyc(c + 6);
        hold_req_n = 1'b1;
        to_cyc(c + 10);
        hold_veto = 1'b0;
        to_cyc(c + 12);

        // R8: veto after the grant changes nothing
        grant_idle();
        c = cyc;
        hold_veto = 1'b1;
        expect_span(c + 1, c + 4, 1'b0, 1'b0, 1'b1, "R8");
        to_cyc(c + 4);
        release_bus();
        hold_veto = 1'b0;
        expect_span(cyc + 1, cyc + 3, 1'b1, 1'b1, 1'b0, "R1");
        to_cyc(cyc + 4);

        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: %0d expectations left unchecked, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule